// File: doc/BRIEF.md
# Dual-Thread Queue with Halt-Driven Capacity Recombination

Two hardware threads share one storage pool of `DEPTH` entries. Each thread has its own push and pop ports, its own full and empty flags, and its own first-in first-out order. When both threads run, neither may hold more than `DEPTH/2` entries. That keeps one busy thread from starving the other. When one thread halts, its share goes back to the survivor, which may then fill the whole pool. When both have halted, the block reports a low-power state.

A halt request is a level input. It is honoured only once the requesting thread has drained its own entries. Until then the thread shows a pending flag, and its pushes are refused. A wake input brings a halted thread back. Entries are kept in per-thread linked lists over the shared pool. A thread therefore always sees its own oldest entry on its read-data port, whatever the other thread does. This is a first-word-fall-through read port: data is valid whenever the thread is not empty.

Top module: `dtq_top`

## Requirements
- R1: After reset both threads are empty and neither is full. The mode output is 0 and low_power is low. No error pulse is present.
- R2: In mode 0 (both active), a thread's full flag is high once it holds `DEPTH/2` entries. A thread's full flag is also high whenever all `DEPTH` entries of the pool are occupied.
- R3: When thread 0's halt is accepted while both threads are active, the mode output becomes 2 (only thread 1 active). Thread 1 may then hold up to `DEPTH` entries.
- R4: When thread 1's halt is accepted while both threads are active, the mode output becomes 1 (only thread 0 active). Thread 0 may then hold up to `DEPTH` entries.
- R5: When the last active thread's halt is accepted, the mode output becomes 3 and low_power goes high.
- R6: A halt of an active thread is accepted at the clock edge where its portion is empty. While the thread is active, halting and not yet empty, halt_pending is high. While its halt input is high, its full flag is high and its pushes are refused. Pops stay allowed so that the thread can drain.
- R7: Waking the halted thread in mode 1 or 2 returns the block to mode 0. A thread that holds `DEPTH/2` or more entries then stays full and cannot push. It still pops its remaining entries in order.
- R8: A wake in mode 3 enters mode 1 if only thread 0 woke, mode 2 if only thread 1 woke, and mode 0 if both woke. A wake of an already active thread has no effect.
- R9: Each thread pops its own entries in the order it pushed them. Its read-data port shows its oldest entry whenever it is not empty, independent of the other thread's traffic.
- R10: A push while full and a pop while empty change no state. Either one raises that thread's error output for exactly the following cycle. A halted thread is always full and empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t0_push | input | 1 | Thread 0 push request |
| t0_wdata | input | WIDTH | Thread 0 push data |
| t0_pop | input | 1 | Thread 0 pop request |
| t0_rdata | output | WIDTH | Thread 0 oldest entry |
| t0_full | output | 1 | Thread 0 cannot accept a push |
| t0_empty | output | 1 | Thread 0 holds no entries |
| t0_halt | input | 1 | Thread 0 halt request (level) |
| t0_wake | input | 1 | Thread 0 wake |
| t0_halt_pending | output | 1 | Thread 0 halt waiting for drain |
| t0_err | output | 1 | Thread 0 rejected request, one cycle late |
| t1_push | input | 1 | Thread 1 push request |
| t1_wdata | input | WIDTH | Thread 1 push data |
| t1_pop | input | 1 | Thread 1 pop request |
| t1_rdata | output | WIDTH | Thread 1 oldest entry |
| t1_full | output | 1 | Thread 1 cannot accept a push |
| t1_empty | output | 1 | Thread 1 holds no entries |
| t1_halt | input | 1 | Thread 1 halt request (level) |
| t1_wake | input | 1 | Thread 1 wake |
| t1_halt_pending | output | 1 | Thread 1 halt waiting for drain |
| t1_err | output | 1 | Thread 1 rejected request, one cycle late |
| mode | output | 2 | 0 both, 1 only thread 0, 2 only thread 1, 3 low power |
| low_power | output | 1 | Both threads halted |

## Verification
The block is built with an 8-entry pool. One thread is filled alone to its half limit, and then further, to show the half cap against the pool cap. A directed sequence of halts and wakes visits every mode transition. It separates the recombined full-pool capacity from the split one, and shows an over-limit thread that keeps draining after a wake. Long pseudo-random stretches of simultaneous pushes and pops on both threads interleave the linked lists. They expose any cross-thread ordering or slot-sharing error. A final random stretch also toggles halt and wake, which catches wrong acceptance timing while a thread still holds entries.

// File: rtl/dtq_pkg.sv
package dtq_pkg;
  typedef enum logic [1:0] {
    MODE_BOTH  = 2'd0,
    MODE_ONLY0 = 2'd1,
    MODE_ONLY1 = 2'd2,
    MODE_SLEEP = 2'd3
  } dtq_mode_e;
endpackage

// File: rtl/dtq_mode_ctrl.sv
module dtq_mode_ctrl
  import dtq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] halt_i,
  input  logic [1:0] wake_i,
  input  logic [1:0] empty_i,
  output dtq_mode_e  mode_o,
  output logic [1:0] active_o,
  output logic [1:0] halt_ok_o
);
  dtq_mode_e  mode_q, mode_d;
  logic [1:0] act_next;

  always_comb begin
    active_o[0] = (mode_q == MODE_BOTH) || (mode_q == MODE_ONLY0);
    active_o[1] = (mode_q == MODE_BOTH) || (mode_q == MODE_ONLY1);
    for (int t = 0; t < 2; t++) begin
      halt_ok_o[t] = active_o[t] && halt_i[t] && empty_i[t];
      act_next[t]  = active_o[t] ? !halt_ok_o[t] : wake_i[t];
    end
    case (act_next)
      2'b11:   mode_d = MODE_BOTH;
      2'b01:   mode_d = MODE_ONLY0;
      2'b10:   mode_d = MODE_ONLY1;
      default: mode_d = MODE_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_BOTH;
    else        mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  for (genvar t = 0; t < 2; t++) begin : g_chk
    AST_HALT_ONLY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active_o[t]) |-> $past(empty_i[t])); // R6
  end

  AST_SLEEP_EXIT_NEEDS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == MODE_SLEEP && mode_q != MODE_SLEEP) |-> $past(|wake_i)); // R8
endmodule

// File: rtl/dtq_free_pool.sv
module dtq_free_pool #(
  parameter int DEPTH = 126,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           take_i,
  input  logic [1:0]           give_i,
  input  logic [1:0][PTR_W-1:0] give_idx_i,
  output logic [1:0][PTR_W-1:0] slot_o
);
  logic [DEPTH-1:0] free_q, free_d;

  // thread 0 takes the lowest free slot, thread 1 the highest
  always_comb begin
    slot_o[0] = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (free_q[i]) slot_o[0] = PTR_W'(i);
    slot_o[1] = '0;
    for (int i = 0; i < DEPTH; i++)
      if (free_q[i]) slot_o[1] = PTR_W'(i);
  end

  always_comb begin
    free_d = free_q;
    for (int t = 0; t < 2; t++) begin
      if (take_i[t]) free_d[slot_o[t]] = 1'b0;
      if (give_i[t]) free_d[give_idx_i[t]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) free_q <= '1;
    else        free_q <= free_d;
  end

  AST_DISTINCT_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i[0] && take_i[1]) |-> (slot_o[0] != slot_o[1])); // R9

  for (genvar t = 0; t < 2; t++) begin : g_chk
    AST_TAKE_FROM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      take_i[t] |-> free_q[slot_o[t]]); // R9
    AST_GIVE_USED_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      give_i[t] |-> !free_q[give_idx_i[t]]); // R9
  end
endmodule

// File: rtl/dtq_link_store.sv
module dtq_link_store #(
  parameter int DEPTH = 126,
  parameter int WIDTH = 8,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             push_i,
  input  logic [1:0]             pop_i,
  input  logic [1:0][PTR_W-1:0]  slot_i,
  input  logic [1:0][WIDTH-1:0]  wdata_i,
  output logic [1:0][WIDTH-1:0]  rdata_o,
  output logic [1:0][PTR_W-1:0]  head_o,
  output logic [1:0][CNT_W-1:0]  cnt_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] nxt_q [DEPTH];
  logic [1:0][PTR_W-1:0] tail_w;
  logic [1:0]            link_w;

  for (genvar t = 0; t < 2; t++) begin : g_thr
    logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             restart;

    always_comb begin
      head_d  = head_q;
      tail_d  = tail_q;
      cnt_d   = cnt_q;
      restart = push_i[t] && ((cnt_q == '0) || (cnt_q == CNT_W'(1) && pop_i[t]));
      if (pop_i[t]) head_d = nxt_q[head_q];
      if (push_i[t]) begin
        tail_d = slot_i[t];
        if (restart) head_d = slot_i[t];
      end
      case ({push_i[t], pop_i[t]})
        2'b10:   cnt_d = cnt_q + CNT_W'(1);
        2'b01:   cnt_d = cnt_q - CNT_W'(1);
        default: cnt_d = cnt_q;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        head_q <= '0;
        tail_q <= '0;
        cnt_q  <= '0;
      end else begin
        head_q <= head_d;
        tail_q <= tail_d;
        cnt_q  <= cnt_d;
      end
    end

    assign link_w[t]  = push_i[t] && !restart;
    assign tail_w[t]  = tail_q;
    assign head_o[t]  = head_q;
    assign cnt_o[t]   = cnt_q;
    assign rdata_o[t] = mem_q[head_q];

    AST_CNT_WITHIN_POOL: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH)); // R2
  end

  // payload and link storage carry no reset
  always_ff @(posedge clk) begin
    for (int t = 0; t < 2; t++) begin
      if (push_i[t]) mem_q[slot_i[t]] <= wdata_i[t];
      if (link_w[t]) nxt_q[tail_w[t]] <= slot_i[t];
    end
  end
endmodule

// File: rtl/dtq_top.sv
module dtq_top
  import dtq_pkg::*;
#(
  parameter int DEPTH = 126,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             t0_push,
  input  logic [WIDTH-1:0] t0_wdata,
  input  logic             t0_pop,
  output logic [WIDTH-1:0] t0_rdata,
  output logic             t0_full,
  output logic             t0_empty,
  input  logic             t0_halt,
  input  logic             t0_wake,
  output logic             t0_halt_pending,
  output logic             t0_err,
  input  logic             t1_push,
  input  logic [WIDTH-1:0] t1_wdata,
  input  logic             t1_pop,
  output logic [WIDTH-1:0] t1_rdata,
  output logic             t1_full,
  output logic             t1_empty,
  input  logic             t1_halt,
  input  logic             t1_wake,
  output logic             t1_halt_pending,
  output logic             t1_err,
  output logic [1:0]       mode,
  output logic             low_power
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int HALF  = DEPTH / 2;

  dtq_mode_e             mode_w;
  logic [1:0]            push_v, pop_v, halt_v, wake_v;
  logic [1:0]            active, empty_v, full_v, acc_push, acc_pop, halt_ok, pend_v;
  logic [1:0]            err_q, err_d;
  logic [1:0][WIDTH-1:0] wdata_v, rdata_v;
  logic [1:0][PTR_W-1:0] slot_v, head_v;
  logic [1:0][CNT_W-1:0] cnt_v;
  logic [CNT_W:0]        total;
  logic                  pool_full;

  assign push_v  = {t1_push, t0_push};
  assign pop_v   = {t1_pop, t0_pop};
  assign halt_v  = {t1_halt, t0_halt};
  assign wake_v  = {t1_wake, t0_wake};
  assign wdata_v = {t1_wdata, t0_wdata};

  assign total     = {1'b0, cnt_v[0]} + {1'b0, cnt_v[1]};
  assign pool_full = (total >= (CNT_W + 1)'(DEPTH));

  for (genvar t = 0; t < 2; t++) begin : g_gate
    logic over_half;
    assign empty_v[t]  = (cnt_v[t] == '0);
    assign over_half   = (mode_w == MODE_BOTH) && (cnt_v[t] >= CNT_W'(HALF));
    assign full_v[t]   = !active[t] || halt_v[t] || over_half || pool_full;
    assign acc_push[t] = push_v[t] && !full_v[t];
    assign acc_pop[t]  = pop_v[t] && !empty_v[t];
    assign pend_v[t]   = active[t] && halt_v[t] && !empty_v[t];
    assign err_d[t]    = (push_v[t] && full_v[t]) || (pop_v[t] && empty_v[t]);

    AST_OVERLIMIT_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_w == MODE_BOTH && cnt_v[t] >= CNT_W'(HALF)) |=> (cnt_v[t] <= $past(cnt_v[t]))); // R7
    AST_REJECT_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_push[t] && !acc_pop[t]) |=> $stable(cnt_v[t])); // R10
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= err_d;
  end

  dtq_mode_ctrl u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt_i    (halt_v),
    .wake_i    (wake_v),
    .empty_i   (empty_v),
    .mode_o    (mode_w),
    .active_o  (active),
    .halt_ok_o (halt_ok)
  );

  dtq_free_pool #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_pool (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_i     (acc_push),
    .give_i     (acc_pop),
    .give_idx_i (head_v),
    .slot_o     (slot_v)
  );

  dtq_link_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (acc_push),
    .pop_i   (acc_pop),
    .slot_i  (slot_v),
    .wdata_i (wdata_v),
    .rdata_o (rdata_v),
    .head_o  (head_v),
    .cnt_o   (cnt_v)
  );

  assign t0_rdata        = rdata_v[0];
  assign t1_rdata        = rdata_v[1];
  assign t0_full         = full_v[0];
  assign t1_full         = full_v[1];
  assign t0_empty        = empty_v[0];
  assign t1_empty        = empty_v[1];
  assign t0_halt_pending = pend_v[0];
  assign t1_halt_pending = pend_v[1];
  assign t0_err          = err_q[0];
  assign t1_err          = err_q[1];
  assign mode            = mode_w;
  assign low_power       = (mode_w == MODE_SLEEP);

  AST_STORAGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    total <= (CNT_W + 1)'(DEPTH)); // R2
  AST_SLEEP_IS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    low_power |-> (empty_v == 2'b11)); // R5
  AST_ACCEPT_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (|halt_ok) |-> !(|(halt_ok & acc_push))); // R6
endmodule

// File: tb/dtq_top_test.sv
`timescale 1ns/1ps
module dtq_top_test;
  localparam int D = 8;
  localparam int H = D / 2;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic t0_push = 0, t0_pop = 0, t0_halt = 0, t0_wake = 0;
  logic t1_push = 0, t1_pop = 0, t1_halt = 0, t1_wake = 0;
  logic [W-1:0] t0_wdata = '0, t1_wdata = '0;
  logic [W-1:0] t0_rdata, t1_rdata;
  logic t0_full, t0_empty, t0_halt_pending, t0_err;
  logic t1_full, t1_empty, t1_halt_pending, t1_err;
  logic [1:0] mode;
  logic low_power;

  int checks = 0;
  int fails = 0;
  int mmode = 0;
  bit merr0 = 0, merr1 = 0;
  logic [W-1:0] mq0[$];
  logic [W-1:0] mq1[$];
  logic [W-1:0] seq0 = 8'h00, seq1 = 8'h80;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  dtq_top #(.DEPTH(D), .WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n),
    .t0_push(t0_push), .t0_wdata(t0_wdata), .t0_pop(t0_pop), .t0_rdata(t0_rdata),
    .t0_full(t0_full), .t0_empty(t0_empty), .t0_halt(t0_halt), .t0_wake(t0_wake),
    .t0_halt_pending(t0_halt_pending), .t0_err(t0_err),
    .t1_push(t1_push), .t1_wdata(t1_wdata), .t1_pop(t1_pop), .t1_rdata(t1_rdata),
    .t1_full(t1_full), .t1_empty(t1_empty), .t1_halt(t1_halt), .t1_wake(t1_wake),
    .t1_halt_pending(t1_halt_pending), .t1_err(t1_err),
    .mode(mode), .low_power(low_power)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit m_full(input int t, input bit h);
    int c0 = mq0.size();
    int c1 = mq1.size();
    int c  = (t == 0) ? c0 : c1;
    bit a  = (t == 0) ? (mmode == 0 || mmode == 1) : (mmode == 0 || mmode == 2);
    return !a || h || (mmode == 0 && c >= H) || (c0 + c1 >= D);
  endfunction

  // compare every output with the model; inputs still hold the previous step's values
  task automatic check_all(input string req);
    bit a0 = (mmode == 0 || mmode == 1);
    bit a1 = (mmode == 0 || mmode == 2);
    bit e0 = (mq0.size() == 0);
    bit e1 = (mq1.size() == 0);
    chk(mode == 2'(mmode), req, "mode", mode, mmode);
    chk(low_power == (mmode == 3), req, "low_power", low_power, mmode == 3);
    chk(t0_empty == e0, req, "t0_empty", t0_empty, e0);
    chk(t1_empty == e1, req, "t1_empty", t1_empty, e1);
    chk(t0_full == m_full(0, t0_halt), req, "t0_full", t0_full, m_full(0, t0_halt));
    chk(t1_full == m_full(1, t1_halt), req, "t1_full", t1_full, m_full(1, t1_halt));
    chk(t0_halt_pending == (a0 && t0_halt && !e0), req, "t0_halt_pending", t0_halt_pending, a0 && t0_halt && !e0);
    chk(t1_halt_pending == (a1 && t1_halt && !e1), req, "t1_halt_pending", t1_halt_pending, a1 && t1_halt && !e1);
    chk(t0_err == merr0, req, "t0_err", t0_err, merr0);
    chk(t1_err == merr1, req, "t1_err", t1_err, merr1);
    if (!e0) chk(t0_rdata == mq0[0], req, "t0_rdata", t0_rdata, mq0[0]);
    if (!e1) chk(t1_rdata == mq1[0], req, "t1_rdata", t1_rdata, mq1[0]);
  endtask

  task automatic step(input string req, input bit p0, input bit p1, input bit o0, input bit o1,
                      input bit h0, input bit h1, input bit w0, input bit w1);
    bit a0, a1, f0, f1, e0, e1, k0, k1, n0, n1;
    @(negedge clk);
    check_all(req);
    t0_push = p0; t1_push = p1; t0_pop = o0; t1_pop = o1;
    t0_halt = h0; t1_halt = h1; t0_wake = w0; t1_wake = w1;
    t0_wdata = seq0; t1_wdata = seq1;
    a0 = (mmode == 0 || mmode == 1);
    a1 = (mmode == 0 || mmode == 2);
    f0 = m_full(0, h0);
    f1 = m_full(1, h1);
    e0 = (mq0.size() == 0);
    e1 = (mq1.size() == 0);
    merr0 = (p0 && f0) || (o0 && e0);
    merr1 = (p1 && f1) || (o1 && e1);
    if (o0 && !e0) void'(mq0.pop_front());
    if (o1 && !e1) void'(mq1.pop_front());
    if (p0 && !f0) begin mq0.push_back(seq0); seq0 = seq0 + 8'd1; end
    if (p1 && !f1) begin mq1.push_back(seq1); seq1 = seq1 + 8'd1; end
    k0 = a0 && h0 && e0;
    k1 = a1 && h1 && e1;
    n0 = a0 ? !k0 : w0;
    n1 = a1 ? !k1 : w1;
    mmode = (n0 && n1) ? 0 : n0 ? 1 : n1 ? 2 : 3;
  endtask

  function automatic logic [15:0] nxt(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic sweep(input string req, input int n, input bit with_halt);
    for (int i = 0; i < n; i++) begin
      lfsr = nxt(lfsr);
      step(req, lfsr[0], lfsr[1], lfsr[2] & lfsr[5], lfsr[3] & lfsr[6],
           with_halt && lfsr[10:8] == 3'd0, with_halt && lfsr[13:11] == 3'd0,
           with_halt && lfsr[15:14] == 2'd0, with_halt && lfsr[7:6] == 2'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    step("R1", 0, 0, 0, 0, 0, 0, 0, 0);
    // R2: half limit per thread in mode 0
    for (int i = 0; i < 5; i++) step("R2", 1, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) step("R2", 0, 1, 0, 0, 0, 0, 0, 0);
    // R10: reject and error pulse, then drain thread 1 past empty
    step("R10", 1, 1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) step("R10", 0, 0, 0, 1, 0, 0, 0, 0);
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0);
    // R9: interleaved traffic in mode 0
    sweep("R9", 400, 1'b0);
    // R6: halt held on thread 0 with entries; pushes refused while draining
    step("R6", 1, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 2; i++) step("R6", 1, 0, 0, 0, 1, 0, 0, 0);
    for (int i = 0; i < 7; i++) step("R6", 1, 0, 1, 0, 1, 0, 0, 0);
    // R3: thread 1 alone fills the whole pool
    for (int i = 0; i < 10; i++) step("R3", 0, 1, 0, 0, 0, 0, 0, 0);
    // R7: wake thread 0; thread 1 over limit drains in order
    step("R7", 0, 0, 0, 0, 0, 0, 1, 0);
    step("R7", 0, 1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 10; i++) step("R7", 1, 1, 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) step("R7", 0, 0, 0, 1, 0, 0, 0, 0);
    // R4: halt thread 1, thread 0 takes the whole pool
    for (int i = 0; i < 3; i++) step("R4", 0, 0, 0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 10; i++) step("R4", 1, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 10; i++) step("R4", 0, 0, 1, 0, 0, 0, 0, 0);
    // R5: last thread halts, low power; push while asleep is rejected
    for (int i = 0; i < 2; i++) step("R5", 0, 0, 0, 0, 1, 0, 0, 0);
    step("R5", 1, 1, 1, 0, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 0, 0, 0, 0, 0);
    // R8: wake orders out of low power
    step("R8", 0, 0, 0, 0, 0, 0, 0, 1);
    step("R8", 0, 0, 0, 0, 0, 0, 0, 1);
    step("R8", 0, 0, 0, 0, 0, 1, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 0, 1, 1);
    step("R8", 0, 0, 0, 0, 1, 1, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 0, 1, 0);
    step("R8", 0, 0, 0, 0, 0, 0, 0, 1);
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0);
    // R9: random traffic with halts and wakes
    sweep("R9", 3000, 1'b1);
    @(negedge clk);
    check_all("R9");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule